// File: doc/BRIEF.md
# I2C SCL bit-rate generator

This block produces the serial clock timing for an I2C master. A functional clock is first divided by a programmable prescaler. The result is an internal sampling clock that is delivered as a one-cycle tick strobe. The SCL waveform is then built by counting those ticks: a low phase whose length comes from a low count, followed by a high phase whose length comes from a high count. Each of the two 16-bit timing words carries two counts. The lower byte is used for standard/fast mode and the upper byte for high-speed mode. An operating-mode input chooses which byte pair applies.

Software programs the prescaler and the timing words while the enable input is low. On the clock edge that first sees enable high, those settings are frozen for the whole run. The first cycle after that edge starts a low phase. When enable drops, SCL is released at once, and the prescaler and phase counters return to their start state. The bit engine uses the tick strobe as its sampling clock. The SCL-drive output tells the pad logic to pull the line low.

As an example, with a prescale value of 23 on a 96 MHz clock, the sampling period is 24 cycles. Counts of 13 and 15 then give 20 ticks low and 20 ticks high.

Top module: `scl_rate_gen`

## Requirements
- R1: During and right after reset, `scl_drive_low` and `samp_tick` are 0.
- R2: In every cycle that follows a clock edge at which `enable` was 0, both `scl_drive_low` and `samp_tick` are 0.
- R3: While running with prescale value P, `samp_tick` is a one-cycle pulse. Its first pulse comes P cycles after the first running cycle, and the pulses repeat every P+1 cycles. A P of 0 gives a tick in every cycle.
- R4: In standard mode, the low phase lasts (`scl_low_word[7:0]` + 7) ticks, which is that many times (P+1) cycles.
- R5: In standard mode, the high phase lasts (`scl_high_word[7:0]` + 5) ticks.
- R6: When `hs_sel` is 1 and `scl_low_word[15:8]` and `scl_high_word[15:8]` are not both zero, those upper bytes replace the lower bytes as the low and high counts, using the same +7 and +5 offsets.
- R7: When `hs_sel` is 0, or when both upper bytes are zero, the lower bytes are used.
- R8: Changes to `psc`, the timing words or `hs_sel` while enabled have no effect on the current run.
- R9: The first running cycle, which follows the edge that first samples `enable` high, drives SCL low and begins a full low phase.
- R10: Dropping `enable` partway through a phase releases SCL and stops ticks on the next cycle. Re-enabling then restarts with a full-length low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run enable; settings are captured while it is low |
| hs_sel | input | 1 | Operating mode request: 1 asks for high-speed counts |
| psc | input | 8 | Prescale value P; sampling period is P+1 cycles |
| scl_low_word | input | 16 | Low counts: [7:0] standard/fast, [15:8] high-speed |
| scl_high_word | input | 16 | High counts: [7:0] standard/fast, [15:8] high-speed |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| samp_tick | output | 1 | One-cycle sampling-clock strobe |

## Verification
Two functions can meet in one cycle. The first is the tick that ends a phase and reloads the phase counter. The second is a change of the setting inputs or a drop of `enable`. One test rewrites the prescaler and counts in the first running cycle. It then requires the measured low and high lengths to match the old settings, not the new ones. Another test drops `enable` partway through the low phase. It requires SCL to be released and ticks to stop on the next cycle, and then checks that a fresh run starts with a full, unshortened low phase.

// File: rtl/scl_gen_pkg.sv
// Shared widths and the frozen configuration record for the SCL generator.
package scl_gen_pkg;
    parameter int unsigned PSC_W = 8;     // prescale value width
    parameter int unsigned CNT_W = 8;     // one phase count width
    localparam int unsigned WORD_W = 2 * CNT_W;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] lo_cnt;
        logic [CNT_W-1:0] hi_cnt;
    } scl_cfg_t;
endpackage

// File: rtl/scl_cfg_hold.sv
// Captures the timing settings while the block is disabled and freezes them
// while it runs. The mode pick (high-speed or standard byte pair) is resolved
// here, so the running datapath sees only one low and one high count.
// Assumes the inputs are stable for two cycles before enable rises.
module scl_cfg_hold
    import scl_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              hs_sel,
    input  logic [PSC_W-1:0]  psc_in,
    input  logic [WORD_W-1:0] low_word,
    input  logic [WORD_W-1:0] high_word,
    output scl_cfg_t          cfg_q
);
    logic     hs_pair_set;
    logic     use_hs;
    scl_cfg_t cfg_d;

    // Choose the byte pair that the requested mode and the stored counts call for.
    always_comb begin
        hs_pair_set  = (|low_word[WORD_W-1:CNT_W]) | (|high_word[WORD_W-1:CNT_W]);
        use_hs       = hs_sel & hs_pair_set;
        cfg_d.psc    = psc_in;
        cfg_d.lo_cnt = use_hs ? low_word[WORD_W-1:CNT_W]  : low_word[CNT_W-1:0];
        cfg_d.hi_cnt = use_hs ? high_word[WORD_W-1:CNT_W] : high_word[CNT_W-1:0];
    end

    // Load the settings only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (!enable) begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/scl_prescaler.sv
// Divides the functional clock by (psc + 1) and gives a one-cycle tick at the
// end of each period. It holds at zero while not running, so the first tick
// comes psc cycles after running starts.
module scl_prescaler
    import scl_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    logic [PSC_W-1:0] div_cnt;
    logic             at_end;

    // Detect the last cycle of a sampling period.
    always_comb begin
        at_end = (div_cnt == psc);
        tick   = run & at_end;
    end

    // Count up through the period and wrap; clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
        end else if (at_end) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scl_phase_timer.sv
// Alternates SCL between a low phase of (lo_cnt + LOW_EXTRA) ticks and a high
// phase of (hi_cnt + HIGH_EXTRA) ticks. A down-counter is reloaded at each
// phase edge. The timer waits in the low phase with a full low reload while
// idle, so every run opens with a complete low phase.
module scl_phase_timer
    import scl_gen_pkg::*;
#(
    parameter int unsigned LOW_EXTRA  = 7,
    parameter int unsigned HIGH_EXTRA = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic [CNT_W-1:0] hi_cnt,
    output logic             drive_low
);
    localparam int unsigned PH_W = CNT_W + 1;

    logic [PH_W-1:0] ph_cnt;
    logic            low_q;
    logic [PH_W-1:0] lo_reload;
    logic [PH_W-1:0] hi_reload;

    // Reload values are phase length minus one, because the count ends at zero.
    always_comb begin
        lo_reload = PH_W'(lo_cnt) + PH_W'(LOW_EXTRA - 1);
        hi_reload = PH_W'(hi_cnt) + PH_W'(HIGH_EXTRA - 1);
        drive_low = run & low_q;
    end

    // Step the phase counter on each tick and flip the phase when it expires.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            low_q  <= 1'b1;
            ph_cnt <= lo_reload;
        end else if (tick) begin
            if (ph_cnt == '0) begin
                low_q  <= ~low_q;
                ph_cnt <= low_q ? hi_reload : lo_reload;
            end else begin
                ph_cnt <= ph_cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/scl_rate_gen.sv
// Top of the SCL bit-rate generator. It registers the enable, captures the
// settings while disabled, and wires the prescaler into the phase timer.
// The outputs are a pull-low request for the SCL pad and the sampling tick.
module scl_rate_gen
    import scl_gen_pkg::*;
#(
    parameter int unsigned LOW_EXTRA  = 7,
    parameter int unsigned HIGH_EXTRA = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              hs_sel,
    input  logic [PSC_W-1:0]  psc,
    input  logic [WORD_W-1:0] scl_low_word,
    input  logic [WORD_W-1:0] scl_high_word,
    output logic              scl_drive_low,
    output logic              samp_tick
);
    logic     run_q;
    scl_cfg_t cfg_q;

    // Running starts one cycle after enable is sampled high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= enable;
        end
    end

    scl_cfg_hold i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .hs_sel    (hs_sel),
        .psc_in    (psc),
        .low_word  (scl_low_word),
        .high_word (scl_high_word),
        .cfg_q     (cfg_q)
    );

    scl_prescaler i_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .psc   (cfg_q.psc),
        .tick  (samp_tick)
    );

    scl_phase_timer #(
        .LOW_EXTRA  (LOW_EXTRA),
        .HIGH_EXTRA (HIGH_EXTRA)
    ) i_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .tick      (samp_tick),
        .lo_cnt    (cfg_q.lo_cnt),
        .hi_cnt    (cfg_q.hi_cnt),
        .drive_low (scl_drive_low)
    );
endmodule

// File: rtl/scl_rate_gen_chk.sv
// Property checker for scl_rate_gen. It observes the ports plus the run flag
// and the frozen settings inside the top, and is attached by bind.
module scl_rate_gen_chk
    import scl_gen_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     enable,
    input logic     run_q,
    input logic     samp_tick,
    input logic     scl_drive_low,
    input scl_cfg_t cfg
);
    // R2: a disabled sample leaves the outputs quiet in the next cycle
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !samp_tick));

    // R3: with a prescale above zero a tick never lasts two cycles
    p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_tick && cfg.psc != '0) |=> !samp_tick);

    // R4: during a run SCL only changes phase just after a tick
    p_phase_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !$stable(scl_drive_low)) |-> $past(samp_tick));

    // R8: settings are frozen for the whole run
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> $stable(cfg));

    // R9: a run opens with SCL pulled low
    p_start_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> scl_drive_low);
endmodule

bind scl_rate_gen scl_rate_gen_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .run_q         (run_q),
    .samp_tick     (samp_tick),
    .scl_drive_low (scl_drive_low),
    .cfg           (cfg_q)
);

// File: tb/test_scl_rate_gen.sv
// Directed bench for scl_rate_gen: one task per scenario, sampling on the
// falling edge and driving inputs there.
module test_scl_rate_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        hs_sel = 1'b0;
    logic [7:0]  psc = '0;
    logic [15:0] scl_low_word = '0;
    logic [15:0] scl_high_word = '0;
    logic        scl_drive_low;
    logic        samp_tick;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scl_rate_gen i_scl_rate_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .hs_sel        (hs_sel),
        .psc           (psc),
        .scl_low_word  (scl_low_word),
        .scl_high_word (scl_high_word),
        .scl_drive_low (scl_drive_low),
        .samp_tick     (samp_tick)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic setup(input int p, input int lw, input int hw, input bit hs);
        @(negedge clk);
        enable = 1'b0;
        psc = 8'(p);
        scl_low_word = 16'(lw);
        scl_high_word = 16'(hw);
        hs_sel = hs;
        repeat (3) @(negedge clk);
    endtask

    // Enable, optionally perturb the settings at once, measure one low and one
    // high phase in cycles, then disable.
    task automatic run_measure(input int exp_lo, input int exp_hi, input string req, input bit perturb);
        int n_lo = 0;
        int n_hi = 0;
        enable = 1'b1;
        @(negedge clk);
        if (perturb) begin
            psc = 8'd5;
            scl_low_word = 16'h3232;
            scl_high_word = 16'h2828;
            hs_sel = ~hs_sel;
        end
        check(scl_drive_low == 1'b1, "R9 first running cycle low", int'(scl_drive_low), 1);
        while (scl_drive_low && n_lo < 5000) begin
            n_lo++;
            @(negedge clk);
        end
        while (!scl_drive_low && n_hi < 5000) begin
            n_hi++;
            @(negedge clk);
        end
        check(n_lo == exp_lo, {req, " low phase cycles"}, n_lo, exp_lo);
        check(n_hi == exp_hi, {req, " high phase cycles"}, n_hi, exp_hi);
        enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(scl_drive_low == 1'b0, "R1 reset drive", int'(scl_drive_low), 0);
        check(samp_tick == 1'b0, "R1 reset tick", int'(samp_tick), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(scl_drive_low == 1'b0 && samp_tick == 1'b0, "R1 after reset quiet",
              int'({scl_drive_low, samp_tick}), 0);
    endtask

    task automatic t_disabled();
        int bad = 0;
        setup(0, 16'h0303, 16'h0303, 1'b0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (scl_drive_low || samp_tick) bad++;
        end
        check(bad == 0, "R2 outputs quiet while disabled", bad, 0);
    endtask

    task automatic t_ticks(input int p, input string req);
        int bad = 0;
        int first = -1;
        setup(p, 3, 10, 1'b0);
        enable = 1'b1;
        for (int i = 0; i < 4 * (p + 1) + 2; i++) begin
            @(negedge clk);
            if (samp_tick && first < 0) first = i;
            if (samp_tick != ((i % (p + 1)) == p)) bad++;
        end
        check(first == p, {req, " first tick position"}, first, p);
        check(bad == 0, {req, " tick pattern mismatches"}, bad, 0);
        enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_std_rates();
        setup(23, 13, 15, 1'b0);
        run_measure(20 * 24, 20 * 24, "R4 R5 100k", 1'b0);
        setup(9, 5, 7, 1'b0);
        run_measure(12 * 10, 12 * 10, "R4 R5 400k", 1'b0);
        setup(2, 3, 10, 1'b0);
        run_measure(10 * 3, 15 * 3, "R4 R5 asymmetric", 1'b0);
    endtask

    task automatic t_hs_mode();
        setup(1, 16'h0203, 16'h060A, 1'b1);
        run_measure(9 * 2, 11 * 2, "R6 high-speed counts", 1'b0);
    endtask

    task automatic t_std_fallback();
        setup(1, 16'h0003, 16'h000A, 1'b1);
        run_measure(10 * 2, 15 * 2, "R7 zero upper bytes", 1'b0);
        setup(1, 16'h0203, 16'h060A, 1'b0);
        run_measure(10 * 2, 15 * 2, "R7 hs_sel low", 1'b0);
    endtask

    task automatic t_frozen();
        setup(1, 3, 10, 1'b0);
        run_measure(10 * 2, 15 * 2, "R8 change while enabled", 1'b1);
    endtask

    task automatic t_disable_mid();
        int ticks = 0;
        setup(1, 3, 10, 1'b0);
        enable = 1'b1;
        repeat (7) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(scl_drive_low == 1'b0, "R10 released after disable", int'(scl_drive_low), 0);
        for (int i = 0; i < 10; i++) begin
            if (samp_tick) ticks++;
            @(negedge clk);
        end
        check(ticks == 0, "R10 no ticks after disable", ticks, 0);
        run_measure(10 * 2, 15 * 2, "R10 full restart", 1'b0);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_ticks(4, "R3 psc 4");
        t_ticks(0, "R3 psc 0");
        t_std_rates();
        t_hs_mode();
        t_std_fallback();
        t_frozen();
        t_disable_mid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule